// File: doc/BRIEF.md
# Timer Interrupt Router

The router sits between a bank of hardware timers and the interrupt fabric. Each timer gives it a one-cycle expiry strobe. From the timer's stored configuration, the router decides how that event is delivered. The first option is a one-cycle pulse on one of 32 interrupt lines. The second is a level held on a line, backed by a per-timer status bit. The third is a message-write request that carries an 8-bit vector and an 8-bit destination. The comparators that produce the strobes belong to another block.

Software programs a 64-bit configuration word per timer and a data/address word pair per timer for message delivery. A global legacy-route input moves timers 0 and 1 onto fixed lines. The router checks every programmed line number against an allowed-line mask. It keeps the status register, which is cleared by writing ones. It also drops held levels by itself when a configuration write makes them stale. Message requests wait in a per-timer pending set and leave one at a time over a valid/ready handshake.

Top module: `tirq_router`

## Requirements
- R1: After reset all interrupt lines are low, every status bit is 0, `msi_valid` is low, and every timer configuration is cleared (disabled, edge, line 0, no message).
- R2: An enabled timer whose configuration bit 1 is 0 (edge) drives its line high for exactly one cycle after the expiry strobe, and its status bit stays 0.
- R3: An enabled timer whose configuration bit 1 is 1 (level) sets its status bit on expiry. Its line is held high from the cycle after the strobe until the bit is cleared.
- R4: An expiry has no effect when the timer's enable bit (configuration bit 2) is 0, or when the timer's status bit is already set.
- R5: A status write with a 1 in bit n clears status bit n and drops its line in the next cycle if bit n was set. A 1 in a bit that is already 0, and any 0, leaves the status unchanged.
- R6: The line number is configuration bits 13:9. A nonzero number whose bit is 0 in the allowed-line mask (parameter `ALLOW_MASK`) is stored as 0. Line 0 means not connected: no line ever rises for it, and line 0 of the output is always low.
- R7: While `legacy_en` is high, timers 0 and 1 use lines 2 and 8 and are always edge triggered, whatever their line field, type bit or the allowed-line mask say. Their status bits are cleared, and any line they hold is dropped.
- R8: A timer delivers by message only when its capability bit (parameter `MSG_CAP`) and its configuration bit 14 are both 1 and, for timers 0 and 1, `legacy_en` is low. Message delivery replaces line delivery for that timer. The vector is bits 7:0 of the data word and the destination is bits 19:12 of the address word. `msi_bcast` is high exactly when the destination is 0xFF.
- R9: A configuration write to a timer whose status bit is set clears that bit and drops the old line in the next cycle when the new word disables the interrupt, selects message delivery, selects edge, or changes the line. A write that changes none of these keeps the bit.
- R10: Several timers may share one line. The line is the OR of every set status bit routed to it and every edge pulse routed to it.
- R11: Message requests raised in the same cycle are issued in ascending timer order. A timer's request appears on the output two cycles after its strobe at the earliest. While `msi_valid` is high and `msi_ready` is low, `msi_valid`, `msi_vector`, `msi_dest` and `msi_tmr` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| legacy_en | input | 1 | Global legacy-route enable for timers 0 and 1 |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_idx | input | IDX_W | Timer addressed by the configuration write |
| cfg_wdata | input | 64 | Configuration word: bit 1 level, bit 2 enable, bits 13:9 line, bit 14 message enable; other bits ignored |
| msg_we | input | 1 | Message word pair write strobe |
| msg_idx | input | IDX_W | Timer addressed by the message write |
| msg_wdata | input | 32 | Message data word (vector in bits 7:0) |
| msg_waddr | input | 32 | Message address word (destination in bits 19:12) |
| expire | input | NUM_TMR | Per-timer expiry strobes |
| sts_we | input | 1 | Status write-one-to-clear strobe |
| sts_wdata | input | NUM_TMR | Status clear mask |
| status | output | NUM_TMR | Level status bits |
| irq_lines | output | 32 | Interrupt line vector (registered) |
| msi_valid | output | 1 | Message request valid |
| msi_ready | input | 1 | Message request accepted |
| msi_vector | output | 8 | Message vector |
| msi_dest | output | 8 | Message destination |
| msi_bcast | output | 1 | Destination is broadcast |
| msi_tmr | output | IDX_W | Timer that raised the request |

## Verification
The assertions assume that `msi_ready` is only a function of the consumer, and that `rst` is held for at least one clock before the first check. They also assume that a configuration write and an expiry strobe for the same timer never fall in the same cycle, because that ordering is left to the integrating logic. The stimulus follows these rules. It writes configuration only while no strobe is raised and lowers every strobe after a single cycle. It changes `msi_ready` one time unit after a rising edge, so each handshake is settled well before it is sampled.

// File: rtl/tirq_pkg.sv
package tirq_pkg;
  localparam int LINES   = 32;
  localparam int LINE_W  = 5;
  localparam int CFG_W   = 64;
  localparam int BIT_LVL = 1;
  localparam int BIT_EN  = 2;
  localparam int BIT_RT  = 9;
  localparam int BIT_MSG = 14;
  localparam int VEC_W   = 8;
  localparam int DST_LO  = 12;

  // stored per-timer configuration
  typedef struct packed {
    logic              en;
    logic              lvl;
    logic              msg_en;
    logic [LINE_W-1:0] route;
  } tcfg_t;

  // effective delivery after legacy and capability rules
  typedef struct packed {
    logic              en;
    logic              edge_m;
    logic              msg;
    logic [LINE_W-1:0] line;
  } teff_t;

  function automatic teff_t resolve(tcfg_t c, logic leg, logic [LINE_W-1:0] leg_line, logic cap);
    teff_t e;
    e.en     = c.en;
    e.msg    = cap & c.msg_en & ~leg;
    e.edge_m = leg | ~c.lvl;
    e.line   = leg ? leg_line : c.route;
    return e;
  endfunction
endpackage

// File: rtl/tirq_cfg_bank.sv
module tirq_cfg_bank
  import tirq_pkg::*;
#(
  parameter int                 NUM_TMR    = 8,
  parameter logic [LINES-1:0]   ALLOW_MASK = 32'hFFFF_00FE,
  parameter logic [NUM_TMR-1:0] MSG_CAP    = '1,
  parameter int                 LEG_LINE0  = 2,
  parameter int                 LEG_LINE1  = 8,
  localparam int                IDX_W      = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          legacy_en,
  input  logic                          cfg_we,
  input  logic [IDX_W-1:0]              cfg_idx,
  input  logic [CFG_W-1:0]              cfg_wdata,
  input  logic                          msg_we,
  input  logic [IDX_W-1:0]              msg_idx,
  input  logic [31:0]                   msg_wdata,
  input  logic [31:0]                   msg_waddr,
  output teff_t [NUM_TMR-1:0]           eff,
  output logic  [NUM_TMR-1:0]           rel,
  output logic  [NUM_TMR-1:0][VEC_W-1:0] vec,
  output logic  [NUM_TMR-1:0][VEC_W-1:0] dst
);
  logic unused_bits;
  assign unused_bits = ^{cfg_wdata[CFG_W-1:BIT_MSG+1], cfg_wdata[BIT_RT-1:BIT_EN+1], cfg_wdata[0],
                         msg_wdata[31:VEC_W], msg_waddr[31:DST_LO+VEC_W], msg_waddr[DST_LO-1:0]};

  // the incoming word, line number checked against the allowed mask
  tcfg_t wr_c;
  always_comb begin
    wr_c.en     = cfg_wdata[BIT_EN];
    wr_c.lvl    = cfg_wdata[BIT_LVL];
    wr_c.msg_en = cfg_wdata[BIT_MSG];
    wr_c.route  = cfg_wdata[BIT_RT +: LINE_W];
    if (wr_c.route != '0 && !ALLOW_MASK[wr_c.route]) wr_c.route = '0;
  end

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    localparam bit LEG_T = (t < 2);
    localparam logic [LINE_W-1:0] LL = (t == 0) ? LINE_W'(LEG_LINE0) : LINE_W'(LEG_LINE1);
    tcfg_t cur_q;
    teff_t e_old, e_new;
    logic  wr_hit, leg;

    assign leg    = LEG_T & legacy_en;
    assign wr_hit = cfg_we && (cfg_idx == IDX_W'(t));
    assign e_old  = resolve(cur_q, leg, LL, MSG_CAP[t]);
    assign e_new  = resolve(wr_c, leg, LL, MSG_CAP[t]);
    assign eff[t] = e_old;
    // a held level goes stale under legacy mode or a delivery-changing write
    assign rel[t] = leg | (wr_hit & (~e_new.en | e_new.msg | e_new.edge_m |
                                      (e_new.line != e_old.line)));

    always_ff @(posedge clk) begin
      if (rst) begin
        cur_q  <= '0;
        vec[t] <= '0;
        dst[t] <= '0;
      end else begin
        if (wr_hit) cur_q <= wr_c;
        if (msg_we && msg_idx == IDX_W'(t)) begin
          vec[t] <= msg_wdata[VEC_W-1:0];
          dst[t] <= msg_waddr[DST_LO +: VEC_W];
        end
      end
    end
  end
endmodule

// File: rtl/tirq_line_ctrl.sv
module tirq_line_ctrl
  import tirq_pkg::*;
#(
  parameter int NUM_TMR = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_TMR-1:0]  expire,
  input  teff_t [NUM_TMR-1:0] eff,
  input  logic [NUM_TMR-1:0]  rel,
  input  logic                sts_we,
  input  logic [NUM_TMR-1:0]  sts_wdata,
  output logic [NUM_TMR-1:0]  status_q,
  output logic [LINES-1:0]    lines_q,
  output logic [NUM_TMR-1:0]  msg_req
);
  logic [NUM_TMR-1:0] fire, lvl_set, pulse, w1c, status_n;
  logic [LINES-1:0]   lines_n;

  always_comb begin
    for (int t = 0; t < NUM_TMR; t++) begin
      fire[t]    = expire[t] & eff[t].en & ~status_q[t];
      msg_req[t] = fire[t] & eff[t].msg;
      lvl_set[t] = fire[t] & ~eff[t].msg & ~eff[t].edge_m & (eff[t].line != '0);
      pulse[t]   = fire[t] & ~eff[t].msg &  eff[t].edge_m & (eff[t].line != '0);
    end
    w1c      = sts_we ? (sts_wdata & status_q) : '0;
    status_n = ((status_q & ~w1c) | lvl_set) & ~rel;
    lines_n  = '0;
    for (int t = 0; t < NUM_TMR; t++) begin
      if (status_n[t] || pulse[t]) lines_n[eff[t].line] = 1'b1;
    end
    lines_n[0] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      lines_q  <= '0;
    end else begin
      status_q <= status_n;
      lines_q  <= lines_n;
    end
  end
endmodule

// File: rtl/tirq_msg_queue.sv
module tirq_msg_queue
  import tirq_pkg::*;
#(
  parameter int  NUM_TMR = 8,
  localparam int IDX_W   = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_TMR-1:0]             req,
  input  logic [NUM_TMR-1:0][VEC_W-1:0]  vec,
  input  logic [NUM_TMR-1:0][VEC_W-1:0]  dst,
  input  logic                           msi_ready,
  output logic                           msi_valid,
  output logic [VEC_W-1:0]               msi_vector,
  output logic [VEC_W-1:0]               msi_dest,
  output logic                           msi_bcast,
  output logic [IDX_W-1:0]               msi_tmr
);
  logic [NUM_TMR-1:0] pend_q, take;
  logic [IDX_W-1:0]   pick;
  logic               load;

  // lowest pending timer wins
  always_comb begin
    pick = '0;
    for (int t = NUM_TMR - 1; t >= 0; t--) begin
      if (pend_q[t]) pick = IDX_W'(t);
    end
    load = (pend_q != '0) && (!msi_valid || msi_ready);
    take = '0;
    if (load) take[pick] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q     <= '0;
      msi_valid  <= 1'b0;
      msi_vector <= '0;
      msi_dest   <= '0;
      msi_bcast  <= 1'b0;
      msi_tmr    <= '0;
    end else begin
      pend_q <= (pend_q & ~take) | req;
      if (load) begin
        msi_valid  <= 1'b1;
        msi_vector <= vec[pick];
        msi_dest   <= dst[pick];
        msi_bcast  <= (dst[pick] == 8'hFF);
        msi_tmr    <= pick;
      end else if (msi_ready) begin
        msi_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tirq_router.sv
module tirq_router
  import tirq_pkg::*;
#(
  parameter int                 NUM_TMR    = 8,
  parameter logic [31:0]        ALLOW_MASK = 32'hFFFF_00FE,
  parameter logic [NUM_TMR-1:0] MSG_CAP    = '1,
  parameter int                 LEG_LINE0  = 2,
  parameter int                 LEG_LINE1  = 8,
  localparam int                IDX_W      = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               legacy_en,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [63:0]        cfg_wdata,
  input  logic               msg_we,
  input  logic [IDX_W-1:0]   msg_idx,
  input  logic [31:0]        msg_wdata,
  input  logic [31:0]        msg_waddr,
  input  logic [NUM_TMR-1:0] expire,
  input  logic               sts_we,
  input  logic [NUM_TMR-1:0] sts_wdata,
  output logic [NUM_TMR-1:0] status,
  output logic [31:0]        irq_lines,
  output logic               msi_valid,
  input  logic               msi_ready,
  output logic [7:0]         msi_vector,
  output logic [7:0]         msi_dest,
  output logic               msi_bcast,
  output logic [IDX_W-1:0]   msi_tmr
);
  teff_t [NUM_TMR-1:0]            eff;
  logic  [NUM_TMR-1:0]            rel, msg_req;
  logic  [NUM_TMR-1:0][VEC_W-1:0] vec, dst;

  tirq_cfg_bank #(
    .NUM_TMR(NUM_TMR), .ALLOW_MASK(ALLOW_MASK), .MSG_CAP(MSG_CAP),
    .LEG_LINE0(LEG_LINE0), .LEG_LINE1(LEG_LINE1)
  ) u_cfg (
    .clk(clk), .rst(rst), .legacy_en(legacy_en),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .msg_we(msg_we), .msg_idx(msg_idx), .msg_wdata(msg_wdata), .msg_waddr(msg_waddr),
    .eff(eff), .rel(rel), .vec(vec), .dst(dst)
  );

  tirq_line_ctrl #(.NUM_TMR(NUM_TMR)) u_line (
    .clk(clk), .rst(rst), .expire(expire), .eff(eff), .rel(rel),
    .sts_we(sts_we), .sts_wdata(sts_wdata),
    .status_q(status), .lines_q(irq_lines), .msg_req(msg_req)
  );

  tirq_msg_queue #(.NUM_TMR(NUM_TMR)) u_msg (
    .clk(clk), .rst(rst), .req(msg_req), .vec(vec), .dst(dst),
    .msi_ready(msi_ready), .msi_valid(msi_valid), .msi_vector(msi_vector),
    .msi_dest(msi_dest), .msi_bcast(msi_bcast), .msi_tmr(msi_tmr)
  );
endmodule

// File: rtl/tirq_router_chk.sv
module tirq_router_chk #(
  parameter int  NUM_TMR = 8,
  localparam int IDX_W   = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1
) (
  input logic               clk,
  input logic               rst,
  input logic               legacy_en,
  input logic [NUM_TMR-1:0] expire,
  input logic               sts_we,
  input logic [NUM_TMR-1:0] sts_wdata,
  input logic [NUM_TMR-1:0] status,
  input logic [31:0]        irq_lines,
  input logic               msi_valid,
  input logic               msi_ready,
  input logic [7:0]         msi_vector,
  input logic [7:0]         msi_dest,
  input logic [IDX_W-1:0]   msi_tmr
);
  AST_LINE0_LOW: assert property (@(posedge clk) disable iff (rst) !irq_lines[0]); // R6

  AST_LEGACY_NO_STATUS: assert property (@(posedge clk) disable iff (rst)
    legacy_en |=> (!status[0] && !status[1])); // R7

  AST_MSI_HOLD: assert property (@(posedge clk) disable iff (rst)
    (msi_valid && !msi_ready) |=> (msi_valid && $stable(msi_vector) &&
                                   $stable(msi_dest) && $stable(msi_tmr))); // R11

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_bit
    AST_STATUS_FROM_EXPIRY: assert property (@(posedge clk) disable iff (rst)
      (status[t] && !$past(status[t])) |-> $past(expire[t])); // R3

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (sts_we && sts_wdata[t] && status[t]) |=> !status[t]); // R5
  end
endmodule

bind tirq_router tirq_router_chk #(.NUM_TMR(NUM_TMR)) u_chk (
  .clk(clk), .rst(rst), .legacy_en(legacy_en), .expire(expire),
  .sts_we(sts_we), .sts_wdata(sts_wdata), .status(status), .irq_lines(irq_lines),
  .msi_valid(msi_valid), .msi_ready(msi_ready), .msi_vector(msi_vector),
  .msi_dest(msi_dest), .msi_tmr(msi_tmr)
);

// File: tb/tirq_router_tb.sv
`timescale 1ns/1ps
module tirq_router_tb;
  localparam int N = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          legacy_en = 1'b0;
  logic          cfg_we = 1'b0;
  logic [IW-1:0] cfg_idx = '0;
  logic [63:0]   cfg_wdata = '0;
  logic          msg_we = 1'b0;
  logic [IW-1:0] msg_idx = '0;
  logic [31:0]   msg_wdata = '0, msg_waddr = '0;
  logic [N-1:0]  expire = '0;
  logic          sts_we = 1'b0;
  logic [N-1:0]  sts_wdata = '0;
  logic [N-1:0]  status;
  logic [31:0]   irq_lines;
  logic          msi_valid, msi_ready = 1'b0, msi_bcast;
  logic [7:0]    msi_vector, msi_dest;
  logic [IW-1:0] msi_tmr;

  int n_cmp = 0;
  int n_err = 0;

  typedef struct { int tmr; logic [7:0] vec; logic [7:0] dst; logic bc; } msi_item_t;
  msi_item_t exp_q[$];

  always #2 clk = ~clk;

  tirq_router u_dut (
    .clk(clk), .rst(rst), .legacy_en(legacy_en), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .msg_we(msg_we), .msg_idx(msg_idx), .msg_wdata(msg_wdata),
    .msg_waddr(msg_waddr), .expire(expire), .sts_we(sts_we), .sts_wdata(sts_wdata),
    .status(status), .irq_lines(irq_lines), .msi_valid(msi_valid), .msi_ready(msi_ready),
    .msi_vector(msi_vector), .msi_dest(msi_dest), .msi_bcast(msi_bcast), .msi_tmr(msi_tmr)
  );

  task automatic chk(input string rq, input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got=%0h exp=%0h", rq, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // config word: bit1 level, bit2 enable, 13:9 line, bit14 message; upper half is junk
  task automatic wcfg(input int idx, input bit lvl, input bit en, input int line, input bit msg);
    cfg_idx   = IW'(idx);
    cfg_wdata = 64'hA5A5_0000_0000_0000 | (64'(lvl) << 1) | (64'(en) << 2) |
                (64'(line & 31) << 9) | (64'(msg) << 14);
    cfg_we = 1'b1; tick(); cfg_we = 1'b0;
  endtask

  task automatic wmsg(input int idx, input logic [7:0] v, input logic [7:0] d);
    msg_idx   = IW'(idx);
    msg_wdata = {24'hFACE00, v};
    msg_waddr = 32'hFEE0_0000 | (32'(d) << 12) | 32'h0000_0ABC;
    msg_we = 1'b1; tick(); msg_we = 1'b0;
  endtask

  task automatic fire(input logic [N-1:0] m);
    expire = m; tick(); expire = '0;
  endtask

  task automatic w1c(input logic [N-1:0] m);
    sts_wdata = m; sts_we = 1'b1; tick(); sts_we = 1'b0; sts_wdata = '0;
  endtask

  task automatic push_exp(input int t, input logic [7:0] v, input logic [7:0] d);
    msi_item_t it;
    it.tmr = t; it.vec = v; it.dst = d; it.bc = (d == 8'hFF);
    exp_q.push_back(it);
  endtask

  // scoreboard monitor: handshake settles before the next rising edge
  always @(negedge clk) begin
    if (!rst && msi_valid && msi_ready) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_err++;
        $display("FAIL R8 unexpected message got tmr=%0d exp=none", msi_tmr);
      end else begin
        msi_item_t e;
        e = exp_q.pop_front();
        chk("R11 order", 64'(msi_tmr), 64'(e.tmr));
        chk("R8 vector", 64'(msi_vector), 64'(e.vec));
        chk("R8 dest", 64'(msi_dest), 64'(e.dst));
        chk("R8 bcast", 64'(msi_bcast), 64'(e.bc));
      end
    end
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_err++;
    $display("FAIL watchdog got=running exp=done");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    chk("R1 lines", 64'(irq_lines), 0);
    chk("R1 status", 64'(status), 0);
    chk("R1 valid", 64'(msi_valid), 0);
    fire(8'hFF);
    chk("R1 cleared config ignores expiry", 64'(irq_lines), 0);
    tick();

    // R2 edge pulse
    wcfg(2, 0, 1, 5, 0);
    fire(8'h04);
    chk("R2 pulse", 64'(irq_lines), 64'h20);
    chk("R2 status", 64'(status), 0);
    tick();
    chk("R2 one cycle", 64'(irq_lines), 0);

    // R3 level
    wcfg(4, 1, 1, 7, 0);
    fire(8'h10);
    chk("R3 status", 64'(status), 64'h10);
    chk("R3 line", 64'(irq_lines), 64'h80);
    repeat (3) tick();
    chk("R3 held", 64'(irq_lines), 64'h80);

    // R4 ignored expiries
    fire(8'h10);
    chk("R4 already set", 64'(status), 64'h10);
    wcfg(5, 0, 0, 3, 0);
    fire(8'h20);
    chk("R4 disabled", 64'(irq_lines), 64'h80);

    // R5 write one to clear
    w1c(8'h28);
    chk("R5 clear bits no effect", 64'(status), 64'h10);
    chk("R5 line kept", 64'(irq_lines), 64'h80);
    w1c(8'h10);
    chk("R5 cleared", 64'(status), 0);
    chk("R5 line dropped", 64'(irq_lines), 0);
    w1c(8'h10);
    chk("R5 clear of zero", 64'(status), 0);

    // R6 line validation
    wcfg(2, 0, 1, 10, 0);
    fire(8'h04);
    chk("R6 disallowed line", 64'(irq_lines), 0);
    wcfg(2, 0, 1, 0, 0);
    fire(8'h04);
    chk("R6 line zero", 64'(irq_lines), 0);
    wcfg(2, 0, 1, 17, 0);
    fire(8'h04);
    chk("R6 allowed line", 64'(irq_lines), 64'h0002_0000);
    tick();

    // R10 shared line
    wcfg(3, 1, 1, 20, 0);
    wcfg(4, 1, 1, 20, 0);
    fire(8'h18);
    chk("R10 shared status", 64'(status), 64'h18);
    chk("R10 shared line", 64'(irq_lines), 64'h0010_0000);
    w1c(8'h08);
    chk("R10 other holds line", 64'(irq_lines), 64'h0010_0000);
    w1c(8'h10);
    chk("R10 all released", 64'(irq_lines), 0);

    // R9 release on reconfiguration
    wcfg(4, 1, 1, 7, 0);
    fire(8'h10);
    wcfg(4, 1, 1, 7, 0);
    chk("R9 same config keeps", 64'(status), 64'h10);
    wcfg(4, 1, 1, 6, 0);
    chk("R9 line change", 64'(status), 0);
    chk("R9 old line dropped", 64'(irq_lines), 0);
    fire(8'h10);
    chk("R9 new line", 64'(irq_lines), 64'h40);
    wcfg(4, 0, 1, 6, 0);
    chk("R9 to edge", 64'(status), 0);
    wcfg(4, 1, 1, 6, 0);
    fire(8'h10);
    wcfg(4, 1, 0, 6, 0);
    chk("R9 disable", 64'(status), 0);
    wcfg(4, 1, 1, 6, 0);
    fire(8'h10);
    wcfg(4, 1, 1, 6, 1);
    chk("R9 to message", 64'(status), 0);
    chk("R9 message line off", 64'(irq_lines), 0);
    wcfg(4, 0, 0, 0, 0);

    // R7 legacy routing
    wcfg(0, 1, 1, 3, 0);
    fire(8'h01);
    chk("R7 pre legacy level", 64'(irq_lines), 64'h08);
    legacy_en = 1'b1;
    tick();
    chk("R7 status released", 64'(status), 0);
    chk("R7 line released", 64'(irq_lines), 0);
    fire(8'h01);
    chk("R7 timer0 line 2", 64'(irq_lines), 64'h04);
    chk("R7 edge forced", 64'(status), 0);
    tick();
    chk("R7 pulse ends", 64'(irq_lines), 0);
    wcfg(1, 1, 1, 5, 0);
    fire(8'h02);
    chk("R7 timer1 line 8", 64'(irq_lines), 64'h100);

    // R8 legacy beats message for timer 0
    wmsg(0, 8'h0A, 8'h01);
    wcfg(0, 0, 1, 0, 1);
    fire(8'h01);
    chk("R8 legacy precedence", 64'(irq_lines), 64'h04);
    repeat (3) tick();
    chk("R8 no message under legacy", 64'(msi_valid), 0);
    legacy_en = 1'b0;
    wcfg(0, 0, 0, 0, 0);
    wcfg(1, 0, 0, 0, 0);

    // R8 / R11 message delivery and ordering
    wmsg(3, 8'h33, 8'h12);
    wmsg(5, 8'h55, 8'h07);
    wmsg(6, 8'h66, 8'hFF);
    wcfg(3, 0, 1, 4, 1);
    wcfg(5, 1, 1, 5, 1);
    wcfg(6, 0, 1, 0, 1);
    push_exp(3, 8'h33, 8'h12);
    push_exp(5, 8'h55, 8'h07);
    push_exp(6, 8'h66, 8'hFF);
    fire(8'h68);
    chk("R8 no line for message", 64'(irq_lines), 0);
    chk("R8 no status for message", 64'(status), 0);
    tick();
    chk("R11 valid", 64'(msi_valid), 1);
    chk("R11 lowest first", 64'(msi_tmr), 3);
    tick();
    chk("R11 hold valid", 64'(msi_valid), 1);
    chk("R11 hold timer", 64'(msi_tmr), 3);
    msi_ready = 1'b1;
    repeat (5) tick();
    chk("R11 drained", 64'(msi_valid), 0);
    chk("R11 all issued", 64'(exp_q.size()), 0);

    finish_run();
  end
endmodule